// File: doc/BRIEF.md
# Cadenced Ringer Tone Sequencer

This block produces ringer and alert tones for a piezo sounder as square waves under command control. One write of a 5-bit command word selects the tone, which is a steady frequency or a 16 Hz warble between two frequencies, and the on/off cadence. The cadence can be continuous, a single make/break cycle, or a double ring with a short first break and a long second break. All frequencies and durations come from one reference clock parameter through rounded integer dividers.

The sounder is driven as a differential pair. During a make interval one leg carries the square wave and the other carries its inverse. During a break both legs are held low, so no voltage appears across the sounder. An indicator output, intended for an LED, is high exactly during make intervals. Writing a new command restarts the cadence at the beginning of a make interval. Writing a stop code silences every output on the next cycle.

Top module: `ring_tone_seq`

## Requirements
- R1: After reset all outputs (`ring_p`, `ring_n`, `led`) are low and stay low until a command is written.
- R2: The tone field is `cmd_data[4:2]`. Code 1 is 400 Hz, code 2 is 1 kHz and code 3 is 2 kHz. Each half period lasts round(CLK_HZ/(2*f)) clock cycles, and the first toggle comes one half period after the write.
- R3: Code 4 warbles between 2 kHz and 2.6 kHz, and code 5 warbles between 1 kHz and 1.3 kHz. The frequency changes every round(CLK_HZ/32) cycles, which gives a 16 Hz alternation, and the lower frequency comes first after a write.
- R4: The cadence field is `cmd_data[1:0]`. Code 1 gives 1 s make and 2 s break, and code 2 gives 0.5 s make and 0.5 s break. One second is 32 ticks, and one tick is round(CLK_HZ/32) cycles.
- R5: Cadence code 3 is a double ring that repeats the sequence make 0.25 s, break 0.25 s, make 0.25 s, break 2.25 s.
- R6: Cadence code 0 is continuous: the make interval never ends.
- R7: During a make interval `ring_n` is the inverse of `ring_p`.
- R8: During a break `ring_p` and `ring_n` are both low. `led` is high exactly during make intervals.
- R9: Tone codes 0, 6 and 7 stop the tone, and all outputs are low from the cycle after the write.
- R10: Writing a command with an active tone (codes 1 to 5) restarts the cadence. `led` is high from the cycle after the write, and the new make interval has its full length even when the write falls in a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe, one cycle |
| cmd_data | input | 5 | Command: [4:2] tone, [1:0] cadence |
| ring_p | output | 1 | Sounder drive, true leg |
| ring_n | output | 1 | Sounder drive, inverted leg |
| led | output | 1 | Cadence indicator, high during make |

## Verification
The hardest situation to reach is the long second break of the double ring, together with the moment the warble switches frequency. Both lie many ticks after a write, and the divider state at that point depends on the whole history since the write. The bench runs the design with a small reference clock (12800 Hz), so one tick is only 400 cycles. It then follows a full double-ring period and measures the tone half period in the middle of the second and third warble windows. Restart is driven by writing a new command while the block is in a break.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [2:0] {
    TONE_OFF  = 3'd0,
    TONE_400  = 3'd1,
    TONE_1K   = 3'd2,
    TONE_2K   = 3'd3,
    TONE_WHI  = 3'd4,
    TONE_WLO  = 3'd5,
    TONE_RS6  = 3'd6,
    TONE_RS7  = 3'd7
  } tone_e;

  typedef enum logic [1:0] {
    CAD_CONT   = 2'd0,
    CAD_SLOW   = 2'd1,
    CAD_MID    = 2'd2,
    CAD_DOUBLE = 2'd3
  } cad_e;

  typedef enum logic [1:0] {
    PH_MAKE1 = 2'd0,
    PH_BRK1  = 2'd1,
    PH_MAKE2 = 2'd2,
    PH_BRK2  = 2'd3
  } phase_e;

  localparam int TICKS_PER_S = 32;
  localparam int DUR_W       = 7;

  // durations in ticks of 1/32 s
  localparam logic [DUR_W-1:0] D_1S   = 7'd32;
  localparam logic [DUR_W-1:0] D_2S   = 7'd64;
  localparam logic [DUR_W-1:0] D_HALF = 7'd16;
  localparam logic [DUR_W-1:0] D_QTR  = 7'd8;
  localparam logic [DUR_W-1:0] D_LONG = 7'd72;

  function automatic int div_round(input int num, input int den);
    return (num + den / 2) / den;
  endfunction

  function automatic int half_cycles(input int clk_hz, input int freq_hz);
    return div_round(clk_hz, 2 * freq_hz);
  endfunction

  function automatic int tick_cycles(input int clk_hz);
    return div_round(clk_hz, TICKS_PER_S);
  endfunction

  function automatic logic tone_active(input tone_e t);
    return (t == TONE_400) || (t == TONE_1K) || (t == TONE_2K) ||
           (t == TONE_WHI) || (t == TONE_WLO);
  endfunction

  function automatic logic [DUR_W-1:0] phase_len(input cad_e c, input phase_e p);
    logic [DUR_W-1:0] d;
    case (c)
      CAD_SLOW:   d = (p == PH_MAKE1) ? D_1S : D_2S;
      CAD_MID:    d = D_HALF;
      CAD_DOUBLE: d = (p == PH_BRK2) ? D_LONG : D_QTR;
      default:    d = D_1S;
    endcase
    return d;
  endfunction

  function automatic phase_e phase_next(input cad_e c, input phase_e p);
    phase_e n;
    case (p)
      PH_MAKE1: n = PH_BRK1;
      PH_BRK1:  n = (c == CAD_DOUBLE) ? PH_MAKE2 : PH_MAKE1;
      PH_MAKE2: n = PH_BRK2;
      default:  n = PH_MAKE1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rts_tick_gen.sv
module rts_tick_gen #(
  parameter int CLK_HZ = 1024000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int TICK_CYC = rts_pkg::tick_cycles(CLK_HZ);
  localparam int CW       = $clog2(TICK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = !restart && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rts_cadence.sv
module rts_cadence
  import rts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  cad_e cad,
  output logic make_on,
  output logic phase_end
);
  phase_e           ph;
  logic [DUR_W-1:0] cnt;
  logic [DUR_W-1:0] len;

  assign len       = phase_len(cad, ph);
  assign phase_end = tick && (cad != CAD_CONT) && (cnt == len - 1'b1);
  assign make_on   = (ph == PH_MAKE1) || (ph == PH_MAKE2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_MAKE1;
      cnt <= '0;
    end else if (restart) begin
      ph  <= PH_MAKE1;
      cnt <= '0;
    end else if (tick && (cad != CAD_CONT)) begin
      if (phase_end) begin
        ph  <= phase_next(cad, ph);
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rts_tone_div.sv
module rts_tone_div
  import rts_pkg::*;
#(
  parameter int CLK_HZ = 1024000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  tick,
  input  tone_e tone,
  output logic  sq,
  output logic  tone_edge
);
  localparam int N400 = half_cycles(CLK_HZ, 400);
  localparam int HW   = $clog2(N400 + 1);
  localparam logic [HW-1:0] H400 = HW'(N400);
  localparam logic [HW-1:0] H1K  = HW'(half_cycles(CLK_HZ, 1000));
  localparam logic [HW-1:0] H1K3 = HW'(half_cycles(CLK_HZ, 1300));
  localparam logic [HW-1:0] H2K  = HW'(half_cycles(CLK_HZ, 2000));
  localparam logic [HW-1:0] H2K6 = HW'(half_cycles(CLK_HZ, 2600));

  logic          warb;
  logic [HW-1:0] dcnt;
  logic [HW-1:0] half;

  always_comb begin
    case (tone)
      TONE_1K:  half = H1K;
      TONE_2K:  half = H2K;
      TONE_WHI: half = warb ? H2K6 : H2K;
      TONE_WLO: half = warb ? H1K3 : H1K;
      default:  half = H400;
    endcase
  end

  assign tone_edge = !restart && (dcnt >= half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warb <= 1'b0;
    end else if (restart) begin
      warb <= 1'b0;
    end else if (tick && ((tone == TONE_WHI) || (tone == TONE_WLO))) begin
      warb <= ~warb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      sq   <= 1'b0;
    end else if (restart) begin
      dcnt <= '0;
      sq   <= 1'b0;
    end else if (tone_edge) begin
      dcnt <= '0;
      sq   <= ~sq;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ring_tone_seq.sv
module ring_tone_seq
  import rts_pkg::*;
#(
  parameter int CLK_HZ = 1024000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [4:0] cmd_data,
  output logic       ring_p,
  output logic       ring_n,
  output logic       led
);
  tone_e tone_q;
  cad_e  cad_q;
  logic  cad_tick;
  logic  make_on;
  logic  phase_end;
  logic  sq;
  logic  tone_edge;
  logic  sounding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_q <= TONE_OFF;
      cad_q  <= CAD_CONT;
    end else if (cmd_wr) begin
      tone_q <= tone_e'(cmd_data[4:2]);
      cad_q  <= cad_e'(cmd_data[1:0]);
    end
  end

  rts_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(cmd_wr), .tick(cad_tick)
  );

  rts_cadence u_cad (
    .clk(clk), .rst_n(rst_n), .restart(cmd_wr), .tick(cad_tick),
    .cad(cad_q), .make_on(make_on), .phase_end(phase_end)
  );

  rts_tone_div #(.CLK_HZ(CLK_HZ)) u_tone (
    .clk(clk), .rst_n(rst_n), .restart(cmd_wr), .tick(cad_tick),
    .tone(tone_q), .sq(sq), .tone_edge(tone_edge)
  );

  assign sounding = tone_active(tone_q) && make_on;
  assign ring_p   = sounding && sq;
  assign ring_n   = sounding && !sq;
  assign led      = sounding;
endmodule

// File: rtl/ring_tone_chk.sv
module ring_tone_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [4:0] cmd_data,
  input logic       ring_p,
  input logic       ring_n,
  input logic       led,
  input logic       tick,
  input logic       tone_edge,
  input logic       phase_end
);
  // R7
  diff_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led |-> (ring_p != ring_n));

  // R8
  break_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !led |-> (!ring_p && !ring_n));

  // R9
  stop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && ((cmd_data[4:2] == 3'd0) || (cmd_data[4:2] >= 3'd6))) |=> !led);

  // R10
  restart_make_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (cmd_data[4:2] != 3'd0) && (cmd_data[4:2] < 3'd6)) |=> led);

  // R4
  led_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(led) && !$past(cmd_wr)) |-> ($past(tick) && $past(phase_end)));

  // R2
  tone_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led && $past(led) && !$past(cmd_wr) && (ring_p != $past(ring_p)))
      |-> $past(tone_edge));
endmodule

bind ring_tone_seq ring_tone_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
  .ring_p(ring_p), .ring_n(ring_n), .led(led), .tick(cad_tick),
  .tone_edge(tone_edge), .phase_end(phase_end)
);

// File: tb/tb_ring_tone_seq.sv
module tb_ring_tone_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 12800;
  localparam int TICK       = (CLK_HZ + 16) / 32;
  localparam int NV         = 5;

  // stimulus table: command, tone frequency, make ticks, first break ticks
  localparam logic [4:0] V_CMD  [NV] = '{5'b00101, 5'b01010, 5'b01111, 5'b01100, 5'b10000};
  localparam int         V_FREQ [NV] = '{400, 1000, 2000, 2000, 2000};
  localparam int         V_MAKE [NV] = '{32, 16, 8, 0, 0};
  localparam int         V_BRK  [NV] = '{64, 16, 8, 0, 0};

  logic       clk = 0;
  logic       rst_n = 0;
  logic       cmd_wr = 0;
  logic [4:0] cmd_data = '0;
  logic       ring_p, ring_n, led;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ring_tone_seq #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .ring_p(ring_p), .ring_n(ring_n), .led(led)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_half(input int f);
    return (2 * CLK_HZ + 2 * f) / (4 * f);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [4:0] c);
    @(negedge clk);
    cmd_data = c;
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic count_level(input logic lvl, input int lim, output int n);
    n = 0;
    while (led == lvl && n < lim) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure_half(output int n);
    logic prev;
    int   g;
    prev = ring_p;
    g = 0;
    while (ring_p == prev && g < 1000) begin g++; @(negedge clk); end
    prev = ring_p;
    n = 0;
    while (ring_p == prev && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset and while idle afterwards
    check(!led && !ring_p && !ring_n, "R1 in reset", {led, ring_p, ring_n}, 0);
    rst_n = 1'b1;
    count_level(1'b0, 300, n);
    check(n == 300 && !ring_p && !ring_n, "R1 idle after reset", n, 300);

    for (int i = 0; i < NV; i++) begin
      write_cmd(V_CMD[i]);
      if (V_MAKE[i] == 0) begin
        count_level(1'b1, 2 * TICK, n);
        check(n == 2 * TICK, "R6 continuous make", n, 2 * TICK);
      end else begin
        count_level(1'b1, V_MAKE[i] * TICK + 10, n);
        check(n == V_MAKE[i] * TICK, "R4 make length", n, V_MAKE[i] * TICK);
        check(!ring_p && !ring_n, "R8 break quiet", {ring_p, ring_n}, 0);
        count_level(1'b0, V_BRK[i] * TICK + 10, n);
        check(n == V_BRK[i] * TICK, "R4 break length", n, V_BRK[i] * TICK);
      end
      write_cmd(V_CMD[i]);
      check(ring_n == !ring_p && led, "R7 differential", ring_n, !ring_p);
      measure_half(n);
      check(n == exp_half(V_FREQ[i]), "R2 half period", n, exp_half(V_FREQ[i]));
    end

    // R5: full double ring sequence
    write_cmd(5'b01111);
    count_level(1'b1, 20 * TICK, n);
    check(n == 8 * TICK, "R5 first make", n, 8 * TICK);
    count_level(1'b0, 20 * TICK, n);
    check(n == 8 * TICK, "R5 first break", n, 8 * TICK);
    count_level(1'b1, 20 * TICK, n);
    check(n == 8 * TICK, "R5 second make", n, 8 * TICK);
    count_level(1'b0, 80 * TICK, n);
    check(n == 72 * TICK, "R5 second break", n, 72 * TICK);
    check(led, "R5 cadence repeats", led, 1);

    // R3: warble windows, code 4 then code 5
    write_cmd(5'b10000);
    measure_half(n);
    check(n == exp_half(2000), "R3 high warble window 1", n, exp_half(2000));
    write_cmd(5'b10000);
    repeat (TICK + TICK / 2) @(negedge clk);
    measure_half(n);
    check(n == exp_half(2600), "R3 high warble window 2", n, exp_half(2600));
    write_cmd(5'b10100);
    measure_half(n);
    check(n == exp_half(1000), "R3 low warble window 1", n, exp_half(1000));
    write_cmd(5'b10100);
    repeat (TICK + TICK / 2) @(negedge clk);
    measure_half(n);
    check(n == exp_half(1300), "R3 low warble window 2", n, exp_half(1300));
    repeat (TICK) @(negedge clk);
    measure_half(n);
    check(n == exp_half(1000), "R3 low warble window 3", n, exp_half(1000));

    // R9: stop codes 0 and 7
    write_cmd(5'b00101);
    repeat (100) @(negedge clk);
    write_cmd(5'b00001);
    check(!led && !ring_p && !ring_n, "R9 stop code 0", led, 0);
    count_level(1'b0, 1000, n);
    check(n == 1000, "R9 stays silent", n, 1000);
    write_cmd(5'b01010);
    write_cmd(5'b11110);
    check(!led && !ring_p && !ring_n, "R9 stop code 7", led, 0);

    // R10: new command written during a break restarts make
    write_cmd(5'b00101);
    repeat (32 * TICK + 200) @(negedge clk);
    check(!led, "R10 in break before rewrite", led, 0);
    write_cmd(5'b01010);
    count_level(1'b1, 20 * TICK, n);
    check(n == 16 * TICK, "R10 restarted make", n, 16 * TICK);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule